// File: doc/BRIEF.md
# One-Shot Link Split Start Register

This block is a 16-bit control register that software reaches through a byte-wide write and read port. The low byte holds a 3-bit field that selects how a link is split into lanes. It also holds a write-only launch bit. The high byte is reserved.

Writing 1 to the launch bit sends a single request, with the selected split, toward the link training logic. After that, software polls the data-link-active status to follow progress. The launch can be accepted only once after reset. Later writes of 1 to the launch bit do nothing, and writes of 0 are always harmless. The split field stays writable after the launch, but a new value is only stored. It never causes a second request.

Top module: `bif_start_reg`

## Requirements
- R1: After reset, `cfg_o` and `launch_cfg_o` are 0 and `start_o` is 0.
- R2: A write to lane 0 (`addr_i`=0) stores `wdata_i[2:0]` into the split field. The new value appears on `cfg_o` after the write edge and reads back on `rdata_o[2:0]`.
- R3: Reads of lane 0 return 0 in bits 7:3, so the launch bit (bit 3) always reads 0. Reads of lane 1 return 8'h00.
- R4: Writes to lane 1 change neither `cfg_o` nor `launch_cfg_o`, and they raise no `start_o`.
- R5: The first write to lane 0 with `wdata_i[3]`=1 after reset raises `start_o` for exactly one cycle. That cycle is the one that follows the write edge.
- R6: Alongside that pulse, `launch_cfg_o` carries `wdata_i[2:0]` of the same write, so a write that both sets bit 3 and changes the field launches with the new field. `launch_cfg_o` holds that value afterwards.
- R7: Once a launch has been accepted, later writes with bit 3 set raise no `start_o`. Only reset re-arms the launch.
- R8: Writes to lane 0 after the launch still update `cfg_o`, but they leave `launch_cfg_o` unchanged.
- R9: `link_up_o` equals `link_up_i` delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 1 | Byte lane select: 0 = control byte, 1 = reserved byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the lane on `addr_i` (combinational) |
| start_o | output | 1 | One-cycle launch request |
| cfg_o | output | 3 | Current split field |
| launch_cfg_o | output | 3 | Split field captured when the launch was accepted |
| link_up_i | input | 1 | Data-link-active status from the link |
| link_up_o | output | 1 | Registered copy of `link_up_i` |

## Verification
Directed writes cover five cases:
- a field-only write, which must not launch;
- a high-lane write carrying 8'hFF, which must be ignored;
- a combined field-and-launch write, which separates the new field value from the stale one;
- a repeated launch write, which must fail to pulse;
- a field rewrite after the launch, which separates `cfg_o` from `launch_cfg_o`.

Random lane and data writes then run from a fixed seed, both before and after a mid-run reset. They show whether the first launch is taken from the first qualifying write wherever it falls, and whether reserved bits ever leak into the read data. A toggling link input checks the one-cycle reflection.

// File: rtl/bif_pkg.sv
package bif_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned CFG_W     = 3;
  localparam int unsigned START_BIT = 3;

  typedef enum logic {
    LANE_CTRL = 1'b0,
    LANE_RSVD = 1'b1
  } lane_e;
endpackage

// File: rtl/bif_cfg_field.sv
module bif_cfg_field #(
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] d_i,
  output logic [CFG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/bif_launch_ctrl.sv
module bif_launch_ctrl #(
  parameter int unsigned CFG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             start_o,
  output logic [CFG_W-1:0] launch_cfg_o
);
  logic armed_q;  // cleared on first accepted launch, set only by reset
  logic take;

  assign take = req_i && armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q      <= 1'b1;
      start_o      <= 1'b0;
      launch_cfg_o <= '0;
    end else begin
      start_o <= take;
      if (take) begin
        armed_q      <= 1'b0;
        launch_cfg_o <= cfg_i;
      end
    end
  end
endmodule

// File: rtl/bif_start_reg.sv
module bif_start_reg
  import bif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              start_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CFG_W-1:0]  launch_cfg_o,
  input  logic              link_up_i,
  output logic              link_up_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_W;

  logic wr_ctrl;
  assign wr_ctrl = wr_en_i && (lane_e'(addr_i) == LANE_CTRL);

  bif_cfg_field #(.CFG_W(CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (wr_ctrl),
    .d_i   (wdata_i[CFG_W-1:0]),
    .q_o   (cfg_o)
  );

  bif_launch_ctrl #(.CFG_W(CFG_W)) u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (wr_ctrl && wdata_i[START_BIT]),
    .cfg_i       (wdata_i[CFG_W-1:0]),
    .start_o     (start_o),
    .launch_cfg_o(launch_cfg_o)
  );

  // launch bit and reserved bits read as zero
  always_comb begin
    if (lane_e'(addr_i) == LANE_CTRL) rdata_o = {{PAD_W{1'b0}}, cfg_o};
    else                              rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_up_o <= 1'b0;
    else         link_up_o <= link_up_i;
  end
endmodule

// File: rtl/bif_start_reg_chk.sv
module bif_start_reg_chk
  import bif_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              start_o,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [CFG_W-1:0]  launch_cfg_o,
  input logic              link_up_i,
  input logic              link_up_o
);
  logic fired_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fired_q <= 1'b0;
    else if (start_o) fired_q <= 1'b1;
  end

  AST_RST_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !start_o && cfg_o == '0); // R1
  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !addr_i |=> cfg_o == $past(wdata_i[CFG_W-1:0])); // R2
  AST_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:CFG_W] == '0 && (!addr_i || rdata_o == '0)); // R3
  AST_RSVD_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i |=> !start_o && $stable(cfg_o) && $stable(launch_cfg_o)); // R4
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_en_i && !addr_i && wdata_i[START_BIT])); // R5
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R5
  AST_LAUNCH_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> launch_cfg_o == $past(wdata_i[CFG_W-1:0])); // R6
  AST_ONCE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !fired_q); // R7
  AST_LAUNCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_q |-> $stable(launch_cfg_o)); // R8
  AST_LINK_REFLECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_up_o) |-> $past(link_up_i)); // R9
endmodule

bind bif_start_reg bif_start_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .start_o     (start_o),
  .cfg_o       (cfg_o),
  .launch_cfg_o(launch_cfg_o),
  .link_up_i   (link_up_i),
  .link_up_o   (link_up_o)
);

// File: tb/bif_start_reg_test.sv
`timescale 1ns/1ps
module bif_start_reg_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       start;
  logic [2:0] cfg, lcfg;
  logic       link_in = 1'b0;
  logic       link_out;

  int n_run = 0;
  int n_fail = 0;

  logic [2:0] m_cfg, m_lcfg;
  logic       m_fired;

  always #4 clk = ~clk;

  bif_start_reg uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .start_o(start), .cfg_o(cfg),
    .launch_cfg_o(lcfg), .link_up_i(link_in), .link_up_o(link_out)
  );

  function automatic logic [7:0] exp_rd(input logic a, input logic [2:0] c);
    return a ? 8'h00 : {5'b0, c};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_cfg = '0; m_lcfg = '0; m_fired = 1'b0;
  endtask

  // write at one edge, then check at the following negedge
  task automatic wr(input logic a, input logic [7:0] d, input string req);
    logic exp_start;
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    exp_start = 1'b0;
    if (!a) begin
      if (d[3] && !m_fired) begin exp_start = 1'b1; m_fired = 1'b1; m_lcfg = d[2:0]; end
      m_cfg = d[2:0];
    end
    chk({req, " start"}, {7'b0, start}, {7'b0, exp_start});
    chk({req, " cfg"}, {5'b0, cfg}, {5'b0, m_cfg});
    chk({req, " launch_cfg"}, {5'b0, lcfg}, {5'b0, m_lcfg});
    @(negedge clk);
    chk("R5 pulse width", {7'b0, start}, 8'h00);
  endtask

  task automatic rd(input logic a, input string req);
    addr = a; #1;
    chk(req, rdata, exp_rd(a, m_cfg));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    chk("R1 start", {7'b0, start}, 8'h00);
    chk("R1 cfg", {5'b0, cfg}, 8'h00);
    chk("R1 launch_cfg", {5'b0, lcfg}, 8'h00);

    wr(1'b0, 8'h05, "R2 field only");
    rd(1'b0, "R2 readback");
    wr(1'b0, 8'hF6, "R3 field with high bits, no launch");
    rd(1'b0, "R3 rsvd bits zero");
    wr(1'b1, 8'hFF, "R4 reserved lane");
    rd(1'b1, "R3 reserved lane reads zero");
    wr(1'b0, 8'h0B, "R6 launch with new field");
    rd(1'b0, "R3 launch bit reads zero");
    wr(1'b0, 8'h0C, "R7 second launch ignored");
    wr(1'b0, 8'h01, "R8 field rewrite after launch");
    wr(1'b0, 8'h00, "R7 write zero harmless");

    // R9 link reflection
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); link_in = i[0] ^ i[2];
      @(negedge clk);
      chk("R9 link reflect", {7'b0, link_out}, {7'b0, link_in});
    end

    // R7 only reset re-arms, then random traffic
    for (int pass = 0; pass < 3; pass++) begin
      do_reset();
      chk("R1 reset clears", {5'b0, lcfg}, 8'h00);
      for (int i = 0; i < 150; i++) begin
        logic       a;
        logic [7:0] d;
        a = ($urandom % 4) == 0;
        d = 8'($urandom);
        if (($urandom % 3) != 0) d[3] = 1'b0;
        wr(a, d, "R5 random write");
        rd(a, "R3 random read");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule